// File: doc/BRIEF.md
# Chainable Converter Serial Output Stage

This block is the digital serial output section of one sampling converter, built so that identical stages can be wired in series. Every stage in a chain shares one serial clock and one active-low select line. The serial output of each stage drives the serial input of the next, and the output of the last stage goes to the host. The analog conversion is outside the block. The held sample arrives as a parallel two's-complement word whose width is a parameter.

When select goes active, each stage copies its held sample into an output shift register and presents the most significant bit. On every falling serial clock edge the register moves one place toward its output. The bit captured from the serial input on the preceding rising edge enters at the bottom. A stage therefore sends its own bits first and then forwards whatever the upstream stage sends. A chain of N stages behaves as one N×B-bit shift register. The host must read that register in a single selected frame, because every new select assertion reloads all the stages. The serial input of the first stage in a chain is tied low.

The serial clock and select are treated as synchronous to the block clock and are edge-detected in that clock domain. The host drives its inputs after a falling serial clock edge and samples the output on the rising edge.

Top module: `adc_chain_stage`

## Requirements
- R1: During reset and in the first cycle after it, `sdo_o` is 0 and the stage counts as deselected.
- R2: A high-to-low transition of `cs_n_i` loads `sample_i` into the shift register. One clock later, `sdo_o` shows sample bit B-1.
- R3: While selected, the stage sends its own sample most significant bit first. It advances by exactly one bit per falling edge of `sclk_i`, and each output bit is stable across the following rising edge.
- R4: `sdi_i` is sampled on each rising edge of `sclk_i` while selected. The bit sampled at serial clock period j (counting from 0 after select) appears on `sdo_o` at frame position B+j, where position 0 is the first bit output.
- R5: In a chain of N stages, the last stage emits a contiguous N×B-bit frame. The frame holds the last stage's sample first, then the upstream samples in chain order toward the first stage, then zeros, because the first stage's serial input is tied low.
- R6: While `cs_n_i` is high, `sdo_o` is 0 from the next clock on. Serial clock edges during that time change neither the output nor the register contents.
- R7: Each new select assertion restarts the frame at the stage's own sample. Reading a chain as several separately selected B-bit frames returns the last stage's sample every time, and a frame cut short and reselected starts over from the new sample.
- R8: The sample width B is 16 or 18, and any other value is rejected at elaboration. The two's-complement sample is forwarded unchanged, so the first bit on the line is its sign bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | SAMPLE_W | Held two's-complement sample from the converter |
| cs_n_i | input | 1 | Shared active-low select / convert strobe |
| sclk_i | input | 1 | Shared serial clock |
| sdi_i | input | 1 | Serial input from the upstream stage (tie low on the first stage) |
| sdo_o | output | 1 | Serial output to the downstream stage or to the host |

## Verification
On every cycle, the assertions check the local mechanics of one stage. A select fall loads the sample, a falling serial clock edge shifts by exactly one place with the captured input bit, a rising edge captures the serial input, and the register holds with a silent output while the stage is deselected. Only the bench scenarios can show the properties of whole frames. These are the ordering of a two-stage 36-bit chain with zeros after it, the forwarding of an arbitrary input stream behind a 16-bit stage's own bits, and the restart behaviour of split or aborted frames. They also cover reading a negative sample back as a signed value.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

    // Edge events derived from one sampled control line.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    // Per-cycle controls for the output shifter.
    typedef struct packed {
        logic load;
        logic shift;
        logic capture;
    } shift_ctl_t;

    // Index of each control line in the edge detector vector.
    localparam int unsigned CTL_SCLK  = 0;
    localparam int unsigned CTL_CS_N  = 1;
    localparam int unsigned CTL_LINES = 2;

    // Idle levels: select inactive (high), serial clock low.
    localparam logic [CTL_LINES-1:0] CTL_IDLE = 2'b10;

    function automatic bit width_supported(input int unsigned w);
        return (w == 16) || (w == 18);
    endfunction

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det
    import adc_chain_pkg::*;
#(
    parameter int unsigned      N    = 2,
    parameter logic [N-1:0]     IDLE = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   sig_i,
    output edge_ev_t [N-1:0] ev_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= IDLE;
        end else begin
            prev_q <= sig_i;
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_line
            assign ev_o[g].rise = sig_i[g] & ~prev_q[g];
            assign ev_o[g].fall = ~sig_i[g] & prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/adc_out_shifter.sv
module adc_out_shifter
    import adc_chain_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  shift_ctl_t   ctl_i,
    input  logic [W-1:0] load_val_i,
    input  logic         ser_i,
    output logic [W-1:0] q_o,
    output logic         cap_o
);

    logic [W-1:0] sreg_q;
    logic         cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
        end else if (ctl_i.capture) begin
            cap_q <= ser_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
        end else if (ctl_i.load) begin
            sreg_q <= load_val_i;
        end else if (ctl_i.shift) begin
            sreg_q <= {sreg_q[W-2:0], cap_q};
        end
    end

    assign q_o   = sreg_q;
    assign cap_o = cap_q;

endmodule

// File: rtl/adc_chain_stage.sv
module adc_chain_stage
    import adc_chain_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 18
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                cs_n_i,
    input  logic                sclk_i,
    input  logic                sdi_i,
    output logic                sdo_o
);

    localparam int unsigned MSB = SAMPLE_W - 1;

    generate
        if (!width_supported(SAMPLE_W)) begin : g_bad_width
            $error("adc_chain_stage: SAMPLE_W must be 16 or 18");
        end
    endgenerate

    edge_ev_t [CTL_LINES-1:0] ev;
    shift_ctl_t               ctl;
    logic [SAMPLE_W-1:0]      sreg;
    logic                     cap;
    logic                     sel_q;

    adc_edge_det #(
        .N    (CTL_LINES),
        .IDLE (CTL_IDLE)
    ) u_edges (
        .clk   (clk),
        .rst   (rst),
        .sig_i ({cs_n_i, sclk_i}),
        .ev_o  (ev)
    );

    // Selected state follows the select line one clock late.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= ~cs_n_i;
        end
    end

    always_comb begin
        ctl.load    = ev[CTL_CS_N].fall;
        ctl.shift   = ev[CTL_SCLK].fall & sel_q & ~cs_n_i;
        ctl.capture = ev[CTL_SCLK].rise & ~cs_n_i;
    end

    adc_out_shifter #(
        .W (SAMPLE_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .load_val_i (sample_i),
        .ser_i      (sdi_i),
        .q_o        (sreg),
        .cap_o      (cap)
    );

    assign sdo_o = sel_q & sreg[MSB];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (sdo_o == 1'b0) && !sel_q);

    // R2
    load_sample_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (sreg == $past(sample_i)) && (sdo_o == $past(sample_i[MSB])));

    // R3
    shift_one_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.shift && !ctl.load) |=> sreg == {$past(sreg[MSB-1:0]), $past(cap)});

    // R4
    capture_sdi_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.capture |=> cap == $past(sdi_i));

    // R6
    idle_output_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_i |=> sdo_o == 1'b0);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && !ctl.load) |=> $stable(sreg));

endmodule

// File: tb/test_adc_chain_stage.sv
module test_adc_chain_stage;

    localparam int unsigned BW = 18;
    localparam int unsigned SW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic          sdi_solo = 1'b0;
    logic [BW-1:0] samp_top = '0;
    logic [BW-1:0] samp_up  = '0;
    logic [SW-1:0] samp_solo = '0;
    logic          sdo_up, sdo_top, sdo_solo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    // First stage of a two-stage chain: serial input tied low.
    adc_chain_stage #(.SAMPLE_W(BW)) u_first (
        .clk(clk), .rst(rst), .sample_i(samp_up), .cs_n_i(cs_n),
        .sclk_i(sclk), .sdi_i(1'b0), .sdo_o(sdo_up));

    // Host-facing stage of the chain.
    adc_chain_stage #(.SAMPLE_W(BW)) i_adc_chain_stage (
        .clk(clk), .rst(rst), .sample_i(samp_top), .cs_n_i(cs_n),
        .sclk_i(sclk), .sdi_i(sdo_up), .sdo_o(sdo_top));

    // Stand-alone 16-bit stage fed by the bench.
    adc_chain_stage #(.SAMPLE_W(SW)) u_solo (
        .clk(clk), .rst(rst), .sample_i(samp_solo), .cs_n_i(cs_n),
        .sclk_i(sclk), .sdi_i(sdi_solo), .sdo_o(sdo_solo));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_chain(input logic [BW-1:0] top,
                                              input logic [BW-1:0] up, input int len);
        logic [63:0] e = '0;
        for (int i = 0; i < len; i++) begin
            if (i < BW)          e[i] = top[BW-1-i];
            else if (i < 2 * BW) e[i] = up[2*BW-1-i];
            else                 e[i] = 1'b0;
        end
        return e;
    endfunction

    function automatic logic [63:0] exp_solo(input logic [SW-1:0] s,
                                             input logic [63:0] pat, input int len);
        logic [63:0] e = '0;
        for (int i = 0; i < len; i++) begin
            e[i] = (i < SW) ? s[SW-1-i] : pat[i-SW];
        end
        return e;
    endfunction

    // Reads len bits; bit k of each result is frame position k.
    task automatic read_bits(input int len, input logic [63:0] pat,
                             output logic [63:0] cb, output logic [63:0] sb);
        cb = '0;
        sb = '0;
        for (int k = 0; k < len; k++) begin
            cb[k] = sdo_top;
            sb[k] = sdo_solo;
            sclk     = 1'b1;
            sdi_solo = pat[k];
            tick(2);
            sclk = 1'b0;
            tick(2);
        end
    endtask

    task automatic frame_check(input int len, input logic [63:0] pat, input string tag);
        logic [63:0] cb, sb, ec, es;
        cs_n = 1'b0;
        tick(2);
        read_bits(len, pat, cb, sb);
        cs_n = 1'b1;
        tick(3);
        ec = exp_chain(samp_top, samp_up, len);
        es = exp_solo(samp_solo, pat, len);
        check(cb == ec, {tag, " R3 R5 chain frame"}, cb, ec);
        check(sb == es, {tag, " R4 solo frame"}, sb, es);
    endtask

    initial begin
        logic [63:0] cb, sb, pat;
        void'($urandom(32'h5eed_0417));
        tick(4);
        // R1: outputs quiet during reset
        check(sdo_top == 0 && sdo_solo == 0, "R1 in reset", {62'b0, sdo_top, sdo_solo}, 0);
        rst = 1'b0;
        tick(1);
        check(sdo_top == 0 && sdo_solo == 0, "R1 after reset", {62'b0, sdo_top, sdo_solo}, 0);

        // R2: MSB visible right after select falls
        samp_top  = 18'h2_0001;
        samp_up   = 18'h1_5A5A;
        samp_solo = 16'h7FFF;
        cs_n = 1'b0;
        tick(2);
        check(sdo_top == 1'b1, "R2 top msb", sdo_top, 1);
        check(sdo_solo == 1'b0, "R2 solo msb", sdo_solo, 0);
        cs_n = 1'b1;
        tick(3);

        // R5: full 36-bit chain frame and trailing zeros
        frame_check(36, 64'h0, "dir36");
        pat = 64'hDEAD_BEEF_1234_5678;
        frame_check(48, pat, "dir48");

        // R8: negative sample read back as signed
        samp_top = 18'h3_FFFB;
        cs_n = 1'b0;
        tick(2);
        read_bits(BW, 64'h0, cb, sb);
        cs_n = 1'b1;
        tick(3);
        begin
            logic [BW-1:0] got;
            for (int i = 0; i < BW; i++) got[BW-1-i] = cb[i];
            check($signed(got) == -5, "R8 signed sample", {46'b0, got}, 64'(-5));
        end

        // R7: split frames each return only the last stage's sample
        samp_top = 18'h0_ABCD;
        samp_up  = 18'h3_1111;
        for (int r = 0; r < 2; r++) begin
            logic [63:0] e;
            cs_n = 1'b0;
            tick(2);
            read_bits(BW, 64'h0, cb, sb);
            cs_n = 1'b1;
            tick(3);
            e = exp_chain(samp_top, samp_up, BW);
            check(cb == e, "R7 split frame", cb, e);
        end

        // R6 and R7: abort mid-frame, idle clocks, reselect with new sample
        cs_n = 1'b0;
        tick(2);
        read_bits(10, 64'h0, cb, sb);
        cs_n = 1'b1;
        tick(2);
        for (int k = 0; k < 6; k++) begin
            sclk = ~sclk;
            tick(2);
            check(sdo_top == 0 && sdo_solo == 0, "R6 idle output",
                  {62'b0, sdo_top, sdo_solo}, 0);
        end
        sclk = 1'b0;
        tick(2);
        samp_top  = 18'h1_2345;
        samp_up   = 18'h0_6789;
        samp_solo = 16'h8001;
        frame_check(36, 64'hF0F0_F0F0_F0F0_F0F0, "R7 restart");

        // Random frames
        for (int n = 0; n < 20; n++) begin
            int len;
            samp_top  = BW'($urandom);
            samp_up   = BW'($urandom);
            samp_solo = SW'($urandom);
            pat       = {$urandom, $urandom};
            len       = 16 + int'($urandom_range(0, 40));
            frame_check(len, pat, "rand");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule